// File: doc/BRIEF.md
# Bus-Activity Watchdog

This block is a watchdog counter that runs on the system clock. The host does not restart it through a dedicated kick pin. Instead, it restarts the watchdog by running a complete transaction on a two-wire serial bus: a START condition, then later a STOP condition. The block only watches the bus lines and never drives them.

If no START/STOP pair completes within the selected timeout, the active-low output drops. It stays low until a valid pair is seen.

A two-bit period field selects one of three timeout lengths or turns the watchdog off. The field lives in a register that software loads through a write strobe. Its reset default is the longest timeout. Every timeout length is a parameter counted in clock cycles.

Top module: `bus_watchdog`

## Requirements
- R1: After reset, wdo_no is high, the period field holds 00 and the count is zero.
- R2: A START is recognised when the synchronised SDA falls while the synchronised SCL is high in both the current and the previous sample. A STOP is recognised when SDA rises under the same SCL condition. A START that repeats before the STOP keeps the pair open.
- R3: The count restarts only at a STOP that follows a START. A START alone has no effect. A STOP with no START before it has no effect.
- R4: The period field selects the timeout. 00 selects T_LONG, 01 selects T_MID and 10 selects T_SHORT. With no restart, wdo_no falls exactly that many clock edges after the restarting edge.
- R5: Period 11 disables the watchdog. The count stays at zero, and wdo_no is high by the second edge after the write.
- R6: Once low, wdo_no stays low until a valid START/STOP pair. That pair returns it high and restarts the count from zero.
- R7: A write (wr_en_i high) loads wr_data_i into the period field and restarts the count. The write alone does not release a low wdo_no.
- R8: SCL and SDA each pass through two synchronising flops. SDA changes while SCL is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line (observed) |
| sda_i | input | 1 | Bus data line (observed) |
| wr_en_i | input | 1 | Period field write strobe |
| wr_data_i | input | 2 | New period code |
| wdo_no | output | 1 | Watchdog expired, active low |

## Verification
The hardest states to reach from the ports are the ones where a bus condition lands while the detector is already holding an open START: a repeated START, and a STOP with no START before it. The stimulus reaches them with separate tasks that move SCL and SDA one at a time, holding each level for several clocks. This lets a STOP-only sequence and a START-only sequence be issued on their own, between full pairs. The stimulus also writes the period field while the output is already low, which checks that a write restarts the count without releasing the output.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  typedef enum logic [1:0] {
    PER_LONG  = 2'b00,
    PER_MID   = 2'b01,
    PER_SHORT = 2'b10,
    PER_OFF   = 2'b11
  } period_e;
endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  // bus idles high, so reset to ones
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bwd_bus_detect.sv
module bwd_bus_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic kick_o
);
  logic scl_q, sda_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // scl must be high on both samples around the sda edge
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
  assign kick_o  = stop_o & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (start_o) armed_q <= 1'b1;
    else if (stop_o)  armed_q <= 1'b0;
  end
endmodule

// File: rtl/bwd_timer.sv
module bwd_timer
  import bwd_pkg::*;
#(
  parameter int T_LONG  = 1000000,
  parameter int T_MID   = 250000,
  parameter int T_SHORT = 50000,
  parameter int CNT_W   = $clog2(T_LONG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_data_i,
  output logic [1:0]       period_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fired_o
);
  period_e          period_q;
  logic [CNT_W-1:0] cnt_q, limit;
  logic             fired_q;

  always_comb begin
    unique case (period_q)
      PER_LONG:  limit = CNT_W'(T_LONG);
      PER_MID:   limit = CNT_W'(T_MID);
      PER_SHORT: limit = CNT_W'(T_SHORT);
      default:   limit = CNT_W'(T_LONG);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      period_q <= PER_LONG;
    else if (wr_en_i) period_q <= period_e'(wr_data_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (kick_i) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (wr_en_i) begin
      cnt_q   <= '0;
    end else if (period_q == PER_OFF) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (!fired_q) begin
      if (cnt_q == limit - CNT_W'(1)) begin
        cnt_q   <= '0;
        fired_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign period_o = period_q;
  assign cnt_o    = cnt_q;
  assign fired_o  = fired_q;
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog #(
  parameter int T_LONG  = 1000000,
  parameter int T_MID   = 250000,
  parameter int T_SHORT = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_data_i,
  output logic       wdo_no
);
  localparam int CNT_W = $clog2(T_LONG + 1);

  logic [1:0]       bus_s;
  logic             start, stop, kick, fired;
  logic [1:0]       period_q;
  logic [CNT_W-1:0] cnt_q;

  bwd_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (bus_s)
  );

  bwd_bus_detect u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (bus_s[1]),
    .sda_i   (bus_s[0]),
    .start_o (start),
    .stop_o  (stop),
    .kick_o  (kick)
  );

  bwd_timer #(
    .T_LONG (T_LONG),
    .T_MID  (T_MID),
    .T_SHORT(T_SHORT),
    .CNT_W  (CNT_W)
  ) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kick_i    (kick),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .period_o  (period_q),
    .cnt_o     (cnt_q),
    .fired_o   (fired)
  );

  assign wdo_no = ~fired;
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int T_LONG = 1000000,
  parameter int CNT_W  = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic             kick_i,
  input logic             wr_en_i,
  input logic [1:0]       period_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             wdo_ni
);
  // R2
  start_stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && stop_i));

  // R3
  kick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (wdo_ni && cnt_i == '0));

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < CNT_W'(T_LONG));

  // R5
  off_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == 2'b11 && !wr_en_i) |=> wdo_ni);

  // R5
  fire_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdo_ni) |-> $past(period_i) != 2'b11);

  // R6
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdo_ni && !kick_i && period_i != 2'b11) |=> !wdo_ni);

  // R7
  wr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_i == '0);
endmodule

bind bus_watchdog bwd_checker #(.T_LONG(T_LONG), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start),
  .stop_i   (stop),
  .kick_i   (kick),
  .wr_en_i  (wr_en_i),
  .period_i (period_q),
  .cnt_i    (cnt_q),
  .wdo_ni   (wdo_no)
);

// File: tb/sim_bus_watchdog.sv
module sim_bus_watchdog;
  localparam int TL = 40, TM = 24, TS = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic wdo_n;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  int  m_cnt = 0, m_per = 0;
  bit  m_fired = 0, m_armed = 0;
  bit  h1c = 1, h2c = 1, h3c = 1, h1d = 1, h2d = 1, h3d = 1;

  always #10 clk = ~clk;

  bus_watchdog #(.T_LONG(TL), .T_MID(TM), .T_SHORT(TS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wdo_no(wdo_n)
  );

  function automatic int lim_of(int p);
    return (p == 0) ? TL : (p == 1) ? TM : TS;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_fired = 0; m_armed = 0;
      h1c = 1; h2c = 1; h3c = 1; h1d = 1; h2d = 1; h3d = 1;
    end else begin
      bit st, sp, kk;
      st = h3c && h2c && h3d && !h2d;
      sp = h3c && h2c && !h3d && h2d;
      kk = sp && m_armed;
      if (st) m_armed = 1; else if (sp) m_armed = 0;
      if (kk) begin m_cnt = 0; m_fired = 0; end
      else if (wr_en) m_cnt = 0;
      else if (m_per == 3) begin m_cnt = 0; m_fired = 0; end
      else if (!m_fired) begin
        if (m_cnt == lim_of(m_per) - 1) begin m_fired = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (wr_en) m_per = int'(wr_data);
      h3c = h2c; h2c = h1c; h1c = scl;
      h3d = h2d; h2d = h1d; h1d = sda;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) check(wdo_n == !m_fired, cur_req, int'(wdo_n), int'(!m_fired));
    if (cycles > 200000) begin
      check(0, "watchdog", cycles, 200000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(logic c, logic d);
    scl = c; sda = d; wait_clk(3);
  endtask

  task automatic bus_start();
    set_pins(scl, 1'b1); set_pins(1'b1, 1'b1); set_pins(1'b1, 1'b0); set_pins(1'b0, 1'b0);
  endtask

  task automatic bus_stop();
    set_pins(1'b0, sda); set_pins(1'b0, 1'b0); set_pins(1'b1, 1'b0); set_pins(1'b1, 1'b1);
  endtask

  task automatic write_per(logic [1:0] v);
    wr_data = v; wr_en = 1'b1; wait_clk(1); wr_en = 1'b0;
  endtask

  initial begin
    wait_clk(3);
    check(wdo_n == 1'b1, "R1", int'(wdo_n), 1);
    rst_n = 1'b1;
    wait_clk(1);
    check(wdo_n == 1'b1, "R1", int'(wdo_n), 1);

    cur_req = "R4";
    wait_clk(45);
    check(wdo_n == 1'b0, "R4", int'(wdo_n), 0);

    // sda toggles with scl low are not bus conditions
    cur_req = "R8";
    set_pins(1'b0, 1'b1); set_pins(1'b0, 1'b0); set_pins(1'b0, 1'b1); set_pins(1'b1, 1'b1);
    wait_clk(4);
    check(wdo_n == 1'b0, "R8", int'(wdo_n), 0);

    cur_req = "R3";
    bus_stop();
    wait_clk(4);
    check(wdo_n == 1'b0, "R3", int'(wdo_n), 0);
    bus_start();
    wait_clk(4);
    check(wdo_n == 1'b0, "R3", int'(wdo_n), 0);

    cur_req = "R6";
    bus_stop();
    wait_clk(4);
    check(wdo_n == 1'b1, "R6", int'(wdo_n), 1);
    wait_clk(50);
    check(wdo_n == 1'b0, "R6", int'(wdo_n), 0);
    wait_clk(20);
    check(wdo_n == 1'b0, "R6", int'(wdo_n), 0);

    cur_req = "R7";
    write_per(2'b10);
    wait_clk(20);
    check(wdo_n == 1'b0, "R7", int'(wdo_n), 0);

    cur_req = "R4";
    bus_start(); bus_stop();
    wait_clk(2);
    check(wdo_n == 1'b1, "R4", int'(wdo_n), 1);
    wait_clk(14);
    check(wdo_n == 1'b0, "R4", int'(wdo_n), 0);
    write_per(2'b01);
    bus_start(); bus_stop();
    wait_clk(20);
    check(wdo_n == 1'b1, "R4", int'(wdo_n), 1);
    wait_clk(10);
    check(wdo_n == 1'b0, "R4", int'(wdo_n), 0);

    cur_req = "R5";
    write_per(2'b11);
    wait_clk(2);
    check(wdo_n == 1'b1, "R5", int'(wdo_n), 1);
    wait_clk(80);
    check(wdo_n == 1'b1, "R5", int'(wdo_n), 1);

    cur_req = "R7";
    write_per(2'b00);
    wait_clk(30);
    write_per(2'b00);
    wait_clk(30);
    check(wdo_n == 1'b1, "R7", int'(wdo_n), 1);
    wait_clk(15);
    check(wdo_n == 1'b0, "R7", int'(wdo_n), 0);

    cur_req = "R2";
    bus_start(); bus_start(); bus_stop();
    wait_clk(2);
    check(wdo_n == 1'b1, "R2", int'(wdo_n), 1);
    wait_clk(45);
    check(wdo_n == 1'b0, "R2", int'(wdo_n), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule